// File: doc/BRIEF.md
# Fine-Grained Warp Issue Scheduler

The block decides, in every clock cycle, which of several resident warps sends its next instruction to a shared set of SIMD lanes. Each warp keeps its own program counter and run state inside the scheduler. Switching from one warp to another costs nothing: no context is saved or restored. The grant for a cycle is a combinational function of the stored warp state and of that cycle's ready inputs. When the issuing warp starts a long-latency memory access, that warp parks in a wait state. From the next cycle on, the issue slot goes to another resident warp that is ready.

Each warp runs a two-state machine. `WS_RUN` is the state in which the warp may issue. `WS_MEMWAIT` means the warp has a memory access outstanding. There are two transitions. LOAD_ISSUE takes a warp from `WS_RUN` to `WS_MEMWAIT` when it is granted and the issue is a load. MEM_RETURN takes it from `WS_MEMWAIT` back to `WS_RUN` when its completion pulse arrives. A round-robin pointer holds the most recently granted warp, and the next search starts just after it. The policy aims at keeping the lanes busy rather than at finishing any one warp early: as long as any warp is eligible, some warp issues.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset every warp is in `WS_RUN`. Warp w has program counter `BASE_PC + w*PC_STRIDE`, which with the defaults is 0, 256, 512 and so on. The pointer is set so that warp 0 is searched first.
- R2: A warp is eligible when its `warp_ready` bit is 1 and it is in `WS_RUN`. At most one `grant_onehot` bit is set, and only for an eligible warp. `grant_warp` holds the index of that bit, and `grant_pc` holds that warp's current program counter.
- R3: Whenever at least one warp is eligible, `grant_valid` is 1 in the same cycle.
- R4: The granted warp is the first eligible warp found when searching in rising index order, wrapping from the last warp to warp 0. The search starts one after the warp granted most recently.
- R5: When a grant is given and `issue_is_load` is 0, the granted warp's program counter grows by 1 (modulo 2^PC_W) for the next cycle.
- R6: When a grant is given and `issue_is_load` is 1, the granted warp enters `WS_MEMWAIT` on the next cycle and its program counter is held. From that cycle it cannot be granted, so the slot goes to another eligible warp.
- R7: A warp in `WS_MEMWAIT` stays ineligible, however long it waits, until its `mem_return` bit pulses. It is eligible again on the cycle after the pulse, and its program counter is then one higher than before.
- R8: When no warp is eligible, `grant_valid` is 0, `grant_onehot` is 0, `grant_warp` and `grant_pc` are 0, and no program counter or pointer changes.
- R9: A `mem_return` pulse to a warp that is in `WS_RUN` has no effect on that warp's program counter or state.
- R10: `issue_is_load` has no effect in a cycle with no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| warp_ready | input | NUM_WARPS | Per-warp bit: the warp has an instruction ready this cycle |
| issue_is_load | input | 1 | The instruction being granted this cycle is a long-latency load |
| mem_return | input | NUM_WARPS | Per-warp completion pulse from the memory model |
| grant_valid | output | 1 | An instruction issues this cycle |
| grant_onehot | output | NUM_WARPS | One-hot code of the granted warp |
| grant_warp | output | IDX_W | Index of the granted warp |
| grant_pc | output | PC_W | Program counter of the granted warp |

## Verification
The bench targets four corner cases, each of which a faulty design fails in a visible way. First, a warp that issues a load while it is the only ready warp: a design that fails to park it would keep granting it, and one that parks it for too long would stall its return. Second, the wrap of the round-robin search past the highest warp: a faulty pointer would grant in the wrong order or would starve high-numbered warps. Third, a 300-cycle wait, together with a spurious return pulse to a running warp: either would show as an early regrant or as a program counter that moves. Fourth, random ready patterns with random memory latencies, in which any cycle with an idle slot while some warp was eligible would count as lost throughput.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    typedef enum logic {
        WS_RUN     = 1'b0,
        WS_MEMWAIT = 1'b1
    } warp_state_e;

endpackage

// File: rtl/warp_ctx.sv
module warp_ctx
    import warp_sched_pkg::*;
#(
    parameter int          PC_W     = 16,
    parameter logic [15:0] RESET_PC = 16'd0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic            is_load,
    input  logic            ret,
    input  logic            ready_in,
    output logic            eligible,
    output logic [PC_W-1:0] pc
);

    warp_state_e state_q, state_d;
    logic [PC_W-1:0] pc_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_RUN;
            pc      <= PC_W'(RESET_PC);
        end else begin
            state_q <= state_d;
            pc      <= pc_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pc_d    = pc;
        unique case (state_q)
            WS_RUN: begin
                if (issue && is_load) begin
                    state_d = WS_MEMWAIT;          // LOAD_ISSUE
                end else if (issue) begin
                    pc_d = pc + PC_W'(1);
                end
            end
            WS_MEMWAIT: begin
                if (ret) begin
                    state_d = WS_RUN;              // MEM_RETURN
                    pc_d    = pc + PC_W'(1);
                end
            end
            default: state_d = WS_RUN;
        endcase
    end

    assign eligible = ready_in && (state_q == WS_RUN);

    AST_NO_ISSUE_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_MEMWAIT) |-> !issue);                                  // R7
    AST_SPURIOUS_RET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_RUN && !issue) |=> $stable(pc) && state_q == WS_RUN);  // R9
    AST_LOAD_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_load) |=> (state_q == WS_MEMWAIT) && $stable(pc));       // R6

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     eligible,
    output logic             valid,
    output logic [N-1:0]     onehot,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] last_q;

    always_comb begin
        valid  = 1'b0;
        onehot = '0;
        idx    = '0;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = (int'(last_q) + k) % N;
            if (!valid && eligible[cand]) begin
                valid        = 1'b1;
                idx          = IDX_W'(cand);
                onehot[cand] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= IDX_W'(N - 1);
        end else if (valid) begin
            last_q <= idx;
        end
    end

    AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        (|eligible) |-> valid);                                      // R3
    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((onehot & eligible) == onehot));                  // R2
    AST_IDLE_POINTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(last_q));                                 // R8

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import warp_sched_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int PC_W      = 16,
    parameter int BASE_PC   = 0,
    parameter int PC_STRIDE = 256,
    localparam int IDX_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] warp_ready,
    input  logic                 issue_is_load,
    input  logic [NUM_WARPS-1:0] mem_return,
    output logic                 grant_valid,
    output logic [NUM_WARPS-1:0] grant_onehot,
    output logic [IDX_W-1:0]     grant_warp,
    output logic [PC_W-1:0]      grant_pc
);

    logic [NUM_WARPS-1:0] elig;
    logic [PC_W-1:0]      pcs [NUM_WARPS];
    logic                 pick_valid;
    logic [NUM_WARPS-1:0] pick_onehot;
    logic [IDX_W-1:0]     pick_idx;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        warp_ctx #(
            .PC_W    (PC_W),
            .RESET_PC(16'(BASE_PC + w * PC_STRIDE))
        ) u_ctx (
            .clk     (clk),
            .rst_n   (rst_n),
            .issue   (pick_onehot[w]),
            .is_load (issue_is_load),
            .ret     (mem_return[w]),
            .ready_in(warp_ready[w]),
            .eligible(elig[w]),
            .pc      (pcs[w])
        );
    end

    rr_pick #(
        .N    (NUM_WARPS),
        .IDX_W(IDX_W)
    ) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .eligible(elig),
        .valid   (pick_valid),
        .onehot  (pick_onehot),
        .idx     (pick_idx)
    );

    always_comb begin
        grant_valid  = pick_valid;
        grant_onehot = pick_onehot;
        grant_warp   = pick_valid ? pick_idx : '0;
        grant_pc     = pick_valid ? pcs[pick_idx] : '0;
    end

    AST_ONEHOT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_onehot) && (grant_valid == (|grant_onehot)));          // R2
    AST_LOAD_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && issue_is_load) |=> !grant_onehot[$past(grant_warp)]); // R6
    AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (grant_pc == '0) && (grant_warp == '0));             // R8

endmodule

// File: tb/warp_issue_sched_bench.sv
module warp_issue_sched_bench;

    localparam int N    = 8;
    localparam int PCW  = 16;
    localparam int IDXW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   warp_ready = '0;
    logic           issue_is_load = 1'b0;
    logic [N-1:0]   mem_return = '0;
    logic           grant_valid;
    logic [N-1:0]   grant_onehot;
    logic [IDXW-1:0] grant_warp;
    logic [PCW-1:0] grant_pc;

    always #10 clk = ~clk;

    warp_issue_sched u_warp_issue_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .warp_ready   (warp_ready),
        .issue_is_load(issue_is_load),
        .mem_return   (mem_return),
        .grant_valid  (grant_valid),
        .grant_onehot (grant_onehot),
        .grant_warp   (grant_warp),
        .grant_pc     (grant_pc)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int unsigned m_pc [N];
    bit          m_wait [N];
    int          m_last;
    int          lat [N];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pick(input logic [N-1:0] el, input int last);
        for (int k = 1; k <= N; k++) begin
            if (el[(last + k) % N]) return (last + k) % N;
        end
        return -1;
    endfunction

    // one cycle: drive, check combinational grant, advance model
    task automatic step(input logic [N-1:0] rdy, input bit ld, input logic [N-1:0] ret);
        logic [N-1:0] el;
        int g;
        @(negedge clk);
        warp_ready    = rdy;
        issue_is_load = ld;
        mem_return    = ret;
        #2;
        for (int w = 0; w < N; w++) el[w] = rdy[w] && !m_wait[w];
        g = pick(el, m_last);
        chk(grant_valid == (g >= 0), "R3/R8 grant_valid", grant_valid, g >= 0);
        if (g >= 0) begin
            chk(grant_warp == g, "R4 grant_warp", grant_warp, g);
            chk(grant_onehot == (N'(1) << g), "R2 grant_onehot", grant_onehot, N'(1) << g);
            chk(grant_pc == PCW'(m_pc[g]), "R5/R7 grant_pc", grant_pc, PCW'(m_pc[g]));
        end else begin
            chk(grant_onehot == '0, "R8 grant_onehot idle", grant_onehot, 0);
            chk(grant_pc == '0, "R8 grant_pc idle", grant_pc, 0);
        end
        for (int w = 0; w < N; w++) begin
            if (ret[w] && m_wait[w]) begin
                m_wait[w] = 0;
                m_pc[w]   = (m_pc[w] + 1) % (1 << PCW);
            end
        end
        if (g >= 0) begin
            if (ld) m_wait[g] = 1;
            else    m_pc[g] = (m_pc[g] + 1) % (1 << PCW);
            m_last = g;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7351));
        for (int w = 0; w < N; w++) begin
            m_pc[w] = w * 256; m_wait[w] = 0; lat[w] = 0;
        end
        m_last = N - 1;
        repeat (3) @(posedge clk);
        #2;
        chk(grant_valid == 1'b0, "R1 reset no grant", grant_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R4: all ready, plain issues, order 0..7 then wraps
        for (int i = 0; i < 10; i++) step('1, 1'b0, '0);

        // R10: load flag with nothing ready has no effect
        step('0, 1'b1, '0);
        step('0, 1'b1, '0);

        // R6/R8: only warp 0 ready, issues a load, then nobody eligible
        step(8'h01, 1'b1, '0);
        step(8'h01, 1'b0, '0);
        // R9: spurious return to running warp 3, then grant warp 3
        step(8'h00, 1'b0, 8'h08);
        step(8'h08, 1'b0, '0);
        // R7: long wait of 300 cycles with warp 0 ready but parked
        for (int i = 0; i < 300; i++) step(8'h01, 1'b0, '0);
        step(8'h01, 1'b0, 8'h01);    // return pulse
        step(8'h01, 1'b0, '0);       // eligible again, pc advanced

        // R6: load while others ready switches next cycle
        step('1, 1'b1, '0);
        step('1, 1'b0, '0);
        begin
            logic [N-1:0] r;
            r = '0;
            for (int w = 0; w < N; w++) if (m_wait[w]) r[w] = 1'b1;
            step('0, 1'b0, r);
        end

        // random phase with random-latency memory model
        for (int c = 0; c < 6000; c++) begin
            logic [N-1:0] rdy, ret;
            bit ld;
            ret = '0;
            for (int w = 0; w < N; w++) begin
                if (m_wait[w]) begin
                    if (lat[w] <= 1) ret[w] = 1'b1;
                    else lat[w]--;
                end else if ($urandom_range(0, 19) == 0) begin
                    ret[w] = 1'b1;   // spurious, R9
                end
            end
            rdy = N'($urandom) | N'($urandom);
            ld  = ($urandom_range(0, 3) == 0);
            step(rdy, ld, ret);
            for (int w = 0; w < N; w++) begin
                if (m_wait[w] && !ret[w] && lat[w] <= 1)
                    lat[w] = ($urandom_range(0, 15) == 0) ? int'($urandom_range(100, 300))
                                                          : int'($urandom_range(1, 30));
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule